// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address into a translation entry when the translation lookaside buffer has no match. It takes one request at a time and reads the first-level descriptor from memory through a single-word read port. A first-level descriptor can map a 1 MiB section, point to a second-level table, or be invalid. When it points to a table, the walker reads the second-level descriptor, which maps a 64 KiB large page, maps a 4 KiB small page, or is invalid. Each walk ends with a one-cycle result. The result carries either a decoded fill entry for the TLB or a fault code, and in both cases the protection domain.

The walker is a six-state machine.

- IDLE: `req_ready` is high. An accepted request captures the virtual address and the base register, then moves to L1_REQ.
- L1_REQ: drives the first-level read. When the memory accepts it, the walker moves to L1_WAIT.
- L1_WAIT: waits for the response and decodes it. A table pointer moves to L2_REQ. A section or an invalid descriptor moves to DONE.
- L2_REQ: drives the second-level read. When the memory accepts it, the walker moves to L2_WAIT.
- L2_WAIT: decodes the response and moves to DONE.
- DONE: shows the result for one cycle and returns to IDLE.

The memory port keeps one read outstanding at a time. A read completes when `mem_rsp_valid` is high for one cycle.

Top module: `page_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid`, `res_valid` and `fill_valid` are 0.
- R2: A request is taken only while `req_ready` is high (IDLE). `req_ready` stays low from the cycle after acceptance until the cycle after `res_valid`, when it returns high.
- R3: The first-level read address is `{ttb[31:14], va[31:20], 2'b00}`.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and `mem_addr` does not change.
- R5: A first-level descriptor with bits [1:0] equal to 0 or 3 ends the walk with `res_fault` = 1 (section fault). In that case `res_domain` is 0, no second read is made, and `fill_valid` stays low.
- R6: A first-level descriptor with bits [1:0] = 2 gives `fill_kind` = 3 (section). In that case `fill_va` = va & 0xFFF00000, `fill_pa` = desc & 0xFFF00000, `fill_perms` = desc & 0xC0C, and `res_domain` = desc[8:5].
- R7: A first-level descriptor with bits [1:0] = 1 causes a second read at `{l1[31:10], va[19:12], 2'b00}`.
- R8: A second-level descriptor with bits [1:0] = 1 gives `fill_kind` = 2 (large), with va and pa masked by 0xFFFF0000. Bits [1:0] = 2 gives `fill_kind` = 1 (small), with mask 0xFFFFF000. In both cases `fill_perms` = desc & 0xFFC and `res_domain` = l1[8:5].
- R9: A second-level descriptor with bits [1:0] equal to 0 or 3 gives `res_fault` = 2 (page fault). In that case `res_domain` still equals l1[8:5] and `fill_valid` stays low.
- R10: `res_valid` is high for exactly one cycle per walk. `fill_valid` is high in that same cycle exactly when `res_fault` is 0. The fault code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address to translate |
| ttb | input | 32 | Translation table base |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Walk finished (one cycle) |
| res_fault | output | 2 | 0 none, 1 section fault, 2 page fault |
| res_domain | output | 4 | Domain of the walk |
| fill_valid | output | 1 | TLB fill strobe |
| fill_kind | output | 2 | 1 small, 2 large, 3 section |
| fill_va | output | 32 | Masked virtual base |
| fill_pa | output | 32 | Masked physical base |
| fill_perms | output | 32 | Permission bits of the descriptor |

## Verification
The assertions assume the memory raises `mem_rsp_valid` only while a read is outstanding, and at most once per accepted read. They also assume `ttb` is sampled only at acceptance. The bench stimulus keeps to these conditions. It answers each accepted read exactly once, after a random delay, and it stalls `mem_req_ready` for a random number of cycles to exercise request holding. It drives `req_valid` only while it is waiting for the walker to become idle. Descriptor types are drawn at random beside directed cases for every type code and for all-ones addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int AW        = 32;
    localparam int DOMW      = 4;
    localparam int DOM_LSB   = 5;
    localparam int TBASE_LSB = 14;
    localparam int SECT_LSB  = 20;
    localparam int PAGE_LSB  = 12;
    localparam int L2BASE_LSB = 10;
    localparam logic [AW-1:0] SECT_MASK  = 32'hFFF0_0000;
    localparam logic [AW-1:0] LARGE_MASK = 32'hFFFF_0000;
    localparam logic [AW-1:0] SMALL_MASK = 32'hFFFF_F000;
    localparam logic [AW-1:0] SECT_PERM  = 32'h0000_0C0C;
    localparam logic [AW-1:0] PAGE_PERM  = 32'h0000_0FFC;

    typedef enum logic [2:0] {
        S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0, FLT_SECTION = 2'd1, FLT_PAGE = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        MAP_NONE = 2'd0, MAP_SMALL = 2'd1, MAP_LARGE = 2'd2, MAP_SECTION = 2'd3
    } map_e;

    typedef struct packed {
        map_e             kind;
        fault_e           fault;
        logic [AW-1:0]    va;
        logic [AW-1:0]    pa;
        logic [AW-1:0]    perms;
        logic [DOMW-1:0]  dom;
    } walk_result_t;
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr
    import ptw_pkg::*;
(
    input  logic [AW-1:TBASE_LSB]      tbase,
    input  logic [AW-1:SECT_LSB]       va_sect,
    input  logic [SECT_LSB-1:PAGE_LSB] va_page,
    input  logic [AW-1:L2BASE_LSB]     l2base,
    output logic [AW-1:0]              l1_addr,
    output logic [AW-1:0]              l2_addr
);
    assign l1_addr = {tbase, va_sect, 2'b00};
    assign l2_addr = {l2base, va_page, 2'b00};
endmodule

// File: rtl/ptw_decode.sv
module ptw_decode
    import ptw_pkg::*;
(
    input  logic [AW-1:0]   va,
    input  logic [AW-1:0]   word,
    input  logic [DOMW-1:0] held_dom,
    output logic            l1_table,
    output walk_result_t    l1_res,
    output walk_result_t    l2_res
);
    always_comb begin
        l1_table = 1'b0;
        l1_res   = '0;
        unique case (word[1:0])
            2'b10: begin
                l1_res.kind  = MAP_SECTION;
                l1_res.fault = FLT_NONE;
                l1_res.va    = va & SECT_MASK;
                l1_res.pa    = word & SECT_MASK;
                l1_res.perms = word & SECT_PERM;
                l1_res.dom   = word[DOM_LSB +: DOMW];
            end
            2'b01: l1_table = 1'b1;
            default: begin
                l1_res.kind  = MAP_NONE;
                l1_res.fault = FLT_SECTION;
            end
        endcase
    end

    always_comb begin
        l2_res       = '0;
        l2_res.dom   = held_dom;
        l2_res.perms = word & PAGE_PERM;
        unique case (word[1:0])
            2'b01: begin
                l2_res.kind  = MAP_LARGE;
                l2_res.fault = FLT_NONE;
                l2_res.va    = va & LARGE_MASK;
                l2_res.pa    = word & LARGE_MASK;
            end
            2'b10: begin
                l2_res.kind  = MAP_SMALL;
                l2_res.fault = FLT_NONE;
                l2_res.va    = va & SMALL_MASK;
                l2_res.pa    = word & SMALL_MASK;
            end
            default: begin
                l2_res.kind  = MAP_NONE;
                l2_res.fault = FLT_PAGE;
                l2_res.perms = '0;
            end
        endcase
    end
endmodule

// File: rtl/page_walker.sv
module page_walker
    import ptw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [31:0]   req_va,
    input  logic [31:0]   ttb,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [31:0]   mem_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          res_valid,
    output logic [1:0]    res_fault,
    output logic [3:0]    res_domain,
    output logic          fill_valid,
    output logic [1:0]    fill_kind,
    output logic [31:0]   fill_va,
    output logic [31:0]   fill_pa,
    output logic [31:0]   fill_perms
);
    walk_state_e               state_q, state_d;
    logic [AW-1:0]             va_q;
    logic [AW-1:TBASE_LSB]     tbase_q;
    logic [AW-1:L2BASE_LSB]    l2base_q;
    logic [DOMW-1:0]           dom_q;
    walk_result_t              res_q;

    logic [AW-1:0]             l1_addr, l2_addr;
    logic                      l1_table;
    walk_result_t              l1_res, l2_res;

    ptw_addr u_addr (
        .tbase   (tbase_q),
        .va_sect (va_q[AW-1:SECT_LSB]),
        .va_page (va_q[SECT_LSB-1:PAGE_LSB]),
        .l2base  (l2base_q),
        .l1_addr (l1_addr),
        .l2_addr (l2_addr)
    );

    ptw_decode u_dec (
        .va       (va_q),
        .word     (mem_rsp_data),
        .held_dom (dom_q),
        .l1_table (l1_table),
        .l1_res   (l1_res),
        .l2_res   (l2_res)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid)     state_d = S_L1_REQ;
            S_L1_REQ:  if (mem_req_ready) state_d = S_L1_WAIT;
            S_L1_WAIT: if (mem_rsp_valid) state_d = l1_table ? S_L2_REQ : S_DONE;
            S_L2_REQ:  if (mem_req_ready) state_d = S_L2_WAIT;
            S_L2_WAIT: if (mem_rsp_valid) state_d = S_DONE;
            S_DONE:                       state_d = S_IDLE;
            default:                      state_d = S_IDLE;
        endcase
    end

    // state and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            va_q     <= '0;
            tbase_q  <= '0;
            l2base_q <= '0;
            dom_q    <= '0;
            res_q    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    va_q    <= req_va;
                    tbase_q <= ttb[AW-1:TBASE_LSB];
                end
                S_L1_WAIT: if (mem_rsp_valid) begin
                    l2base_q <= mem_rsp_data[AW-1:L2BASE_LSB];
                    dom_q    <= mem_rsp_data[DOM_LSB +: DOMW];
                    if (!l1_table) res_q <= l1_res;
                end
                S_L2_WAIT: if (mem_rsp_valid) res_q <= l2_res;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
        mem_addr      = (state_q == S_L2_REQ) ? l2_addr : l1_addr;
        res_valid     = (state_q == S_DONE);
        fill_valid    = (state_q == S_DONE) && (res_q.fault == FLT_NONE);
        res_fault     = res_q.fault;
        res_domain    = res_q.dom;
        fill_kind     = res_q.kind;
        fill_va       = res_q.va;
        fill_pa       = res_q.pa;
        fill_perms    = res_q.perms;
    end
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_addr,
    input logic        res_valid,
    input logic [1:0]  res_fault,
    input logic        fill_valid
);
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_back_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> req_ready);
    p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !res_valid));
    p_fault_nofill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != 2'd0) |-> !fill_valid);
    p_one_shot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    p_fill_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (res_valid && res_fault == 2'd0));
    p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_fault != 2'd3));
endmodule

bind page_walker page_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .res_valid     (res_valid),
    .res_fault     (res_fault),
    .fill_valid    (fill_valid)
);

// File: tb/page_walker_test.sv
`timescale 1ns/1ps
module page_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] ttb = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [1:0]  res_fault;
    logic [3:0]  res_domain;
    logic        fill_valid;
    logic [1:0]  fill_kind;
    logic [31:0] fill_va, fill_pa, fill_perms;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    page_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .ttb(ttb), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_fault(res_fault), .res_domain(res_domain),
        .fill_valid(fill_valid), .fill_kind(fill_kind), .fill_va(fill_va),
        .fill_pa(fill_pa), .fill_perms(fill_perms)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_l1_addr(logic [31:0] base, logic [31:0] va);
        return ((base & 32'hFFFFC000) | (va >> 18)) & ~32'd3;
    endfunction

    function automatic logic [31:0] f_l2_addr(logic [31:0] d1, logic [31:0] va);
        return ((d1 & 32'hFFFFFC00) | ((va & 32'h000FF000) >> 10)) & ~32'd3;
    endfunction

    // serve one read; on entry the walker is in a request state at a negedge
    task automatic serve(input string tag, input logic [31:0] exp_addr, input logic [31:0] data);
        int stall = int'($urandom % 3);
        int lat = int'($urandom % 3);
        for (int i = 0; i < stall; i++) begin
            chk({tag, " R4 hold valid"}, {31'd0, mem_req_valid}, 32'd1);
            chk({tag, " R4 hold addr"}, mem_addr, exp_addr);
            @(negedge clk);
        end
        chk({tag, " valid"}, {31'd0, mem_req_valid}, 32'd1);
        chk({tag, " addr"}, mem_addr, exp_addr);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R2 busy while waiting", {31'd0, req_ready}, 32'd0);
        for (int i = 0; i < lat; i++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data = $urandom;
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input logic [31:0] d1, input logic [31:0] d2);
        logic [1:0] e_fault = 2'd0;
        logic [1:0] e_kind = 2'd0;
        logic [3:0] e_dom = 4'd0;
        logic [31:0] e_va = '0, e_pa = '0, e_perm = '0;
        string tg = "R10";
        req_valid = 1'b1;
        req_va = va;
        ttb = base;
        @(negedge clk);
        req_valid = 1'b0;
        ttb = $urandom;
        chk("R2 not ready after accept", {31'd0, req_ready}, 32'd0);
        serve("R3 l1", f_l1_addr(base, va), d1);
        case (d1[1:0])
            2'b10: begin
                tg = "R6"; e_kind = 2'd3; e_dom = d1[8:5];
                e_va = va & 32'hFFF00000; e_pa = d1 & 32'hFFF00000; e_perm = d1 & 32'hC0C;
            end
            2'b01: begin
                serve("R7 l2", f_l2_addr(d1, va), d2);
                e_dom = d1[8:5];
                case (d2[1:0])
                    2'b01: begin
                        tg = "R8 large"; e_kind = 2'd2;
                        e_va = va & 32'hFFFF0000; e_pa = d2 & 32'hFFFF0000; e_perm = d2 & 32'hFFC;
                    end
                    2'b10: begin
                        tg = "R8 small"; e_kind = 2'd1;
                        e_va = va & 32'hFFFFF000; e_pa = d2 & 32'hFFFFF000; e_perm = d2 & 32'hFFC;
                    end
                    default: begin tg = "R9"; e_fault = 2'd2; end
                endcase
            end
            default: begin tg = "R5"; e_fault = 2'd1; end
        endcase
        chk({tg, " res_valid"}, {31'd0, res_valid}, 32'd1);
        chk({tg, " fault"}, {30'd0, res_fault}, {30'd0, e_fault});
        chk({tg, " domain"}, {28'd0, res_domain}, {28'd0, e_dom});
        chk({tg, " R10 fill strobe"}, {31'd0, fill_valid}, {31'd0, (e_fault == 2'd0)});
        chk({tg, " no extra read"}, {31'd0, mem_req_valid}, 32'd0);
        if (e_fault == 2'd0) begin
            chk({tg, " kind"}, {30'd0, fill_kind}, {30'd0, e_kind});
            chk({tg, " va"}, fill_va, e_va);
            chk({tg, " pa"}, fill_pa, e_pa);
            chk({tg, " perms"}, fill_perms, e_perm);
        end
        @(negedge clk);
        chk("R10 one-cycle result", {30'd0, res_valid, fill_valid}, 32'd0);
        chk("R2 ready again", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 idle outputs", {29'd0, mem_req_valid, res_valid, fill_valid}, 32'd0);
        // directed corner cases
        walk(32'h1234_5678, 32'hA000_0000, 32'h8765_4DE2, 32'h0);      // section, R6
        walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFF2, 32'h0);      // section, all ones
        walk(32'h0040_3000, 32'h0000_4000, 32'h0000_0000, 32'h0);      // R5 type 0
        walk(32'h0040_3000, 32'h0000_4000, 32'hFFFF_FFFF, 32'h0);      // R5 type 3
        walk(32'hCAFE_B123, 32'h5555_8000, 32'h1234_5DE1, 32'hABCD_EFF1); // R8 large
        walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 32'hFFFF_FFFE); // R8 small
        walk(32'h0ABC_D000, 32'h1000_0000, 32'h0000_0161, 32'h0000_0000); // R9 type 0
        walk(32'h0ABC_D000, 32'h1000_0000, 32'hFFFF_FFE1, 32'hFFFF_FFFF); // R9 type 3
        // random mix
        for (int n = 0; n < 80; n++) begin
            walk($urandom, $urandom, $urandom, $urandom);
            for (int g = 0; g < int'($urandom % 3); g++) @(negedge clk);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule